// File: doc/BRIEF.md
# SPI Hold Condition Gating Unit

This unit sits between the pins of a serial flash slave and its instruction sequencer. It provides the pause function of the serial bus. While the bus master holds the pause pin low, the sequencer sees no clock edges and no valid input data. The data output driver is disabled. The sequencer keeps its partly shifted bits and its command state, so the transfer can carry on once the pause ends. The unit gives no signal to program, erase or status-write cycles, so a pause never stops one of them.

The pins are first brought through a short register chain into the system clock domain. A small state machine then decides between three states: running, paused and locked. A pause may begin or end only while the serial clock pin is low. If the pause pin changes while the clock is high, the change waits until the clock next goes low. The pause pin has no effect while chip select is high. If chip select goes high during a pause, the sequencer is reset and the unit locks the interface. The lock clears only when the master deselects the device and releases the pause pin together, so a new selection cannot fall straight back into the pause.

All four outputs are registered. A pin change shows at the outputs SYNC_STAGES+1 system clocks later, which is 3 clocks with the default settings.

Top module: `hold_gate`

## Requirements
- R1: During reset and in the first cycles after it, seq_sck, seq_din_en, seq_dout_en and seq_rst are all 0, and the unit is in the running state.
- R2: While running with pin_cs_n low, seq_din_en and seq_dout_en are 1 and seq_sck copies pin_sck. Each pin change reaches the outputs SYNC_STAGES+1 clocks later, so every rising edge of pin_sck gives exactly one rising edge of seq_sck.
- R3: If pin_hold_n is low and pin_cs_n is low while pin_sck is low, the pause begins.
- R4: If pin_hold_n goes low while pin_sck is high, the unit keeps running, with the enables at 1 and seq_sck at 1. The pause begins once pin_sck goes low.
- R5: The pause ends when pin_hold_n is high while pin_sck is low. If pin_hold_n rises while pin_sck is high, the unit stays paused until pin_sck goes low.
- R6: While paused, seq_sck, seq_din_en, seq_dout_en and seq_rst are all 0. Pulses on pin_sck produce no edge on seq_sck, so the sequencer state is kept.
- R7: While pin_cs_n is high, seq_din_en and seq_dout_en are 0. pin_hold_n is ignored, so a low pin_hold_n never starts a pause and never leads to a lock.
- R8: If pin_cs_n goes high while paused, the unit locks: seq_rst becomes 1 and seq_sck, seq_din_en and seq_dout_en stay 0.
- R9: A locked unit stays locked until pin_cs_n and pin_hold_n are both high in the same cycle. Driving pin_cs_n low before pin_hold_n is released keeps the lock in place. Once the lock clears, seq_rst returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_sck | input | 1 | Serial clock pin |
| pin_cs_n | input | 1 | Chip select pin, active low |
| pin_hold_n | input | 1 | Pause pin, active low |
| seq_sck | output | 1 | Qualified serial clock to the sequencer |
| seq_din_en | output | 1 | Sequencer may sample the data input |
| seq_dout_en | output | 1 | Data output driver enable |
| seq_rst | output | 1 | Reset to the sequencer's serial logic |

## Verification
The pause pin is swept over both directions of change against both serial clock levels, so that a transition taking effect at once can be told apart from one that is deferred. Clock pulses are counted on seq_sck before, during and after a pause; this shows that a correct gate passes every edge while running and swallows every edge while paused. Deselection is tried in three cases: while running, with the pause pin low while deselected, and during a pause. Recovery from the lock is tried both in the right order and with selection made too early, which shows that the lock clears only when both pins are high together.

// File: rtl/hold_gate_pkg.sv
package hold_gate_pkg;
  typedef enum logic [1:0] {
    HG_RUN   = 2'd0,
    HG_PAUSE = 2'd1,
    HG_LOCK  = 2'd2
  } hg_state_e;

  localparam int PIN_W    = 3;
  localparam int PIN_SCK  = 0;
  localparam int PIN_CS   = 1;
  localparam int PIN_HOLD = 2;
endpackage

// File: rtl/hold_pin_sync.sv
module hold_pin_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int N = (STAGES < 1) ? 1 : STAGES;

  logic [W-1:0] chain [N];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= RST_VAL;
    else     chain[0] <= d;
  end

  for (genvar i = 1; i < N; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[i] <= RST_VAL;
      else     chain[i] <= chain[i-1];
    end
  end

  assign q = chain[N-1];
endmodule

// File: rtl/hold_state_ctl.sv
module hold_state_ctl
  import hold_gate_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      s_sck,
  input  logic      s_cs_n,
  input  logic      s_hold_n,
  output hg_state_e state_q,
  output hg_state_e state_d
);
  logic clk_low;
  assign clk_low = ~s_sck;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      HG_RUN: begin
        if (!s_cs_n && !s_hold_n && clk_low) state_d = HG_PAUSE;
      end
      HG_PAUSE: begin
        if (s_cs_n)                         state_d = HG_LOCK;
        else if (s_hold_n && clk_low)       state_d = HG_RUN;
      end
      HG_LOCK: begin
        if (s_cs_n && s_hold_n)             state_d = HG_RUN;
      end
      default: state_d = HG_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= HG_RUN;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/hold_out_reg.sv
module hold_out_reg
  import hold_gate_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  hg_state_e state_d,
  input  logic      s_sck,
  input  logic      s_cs_n,
  output logic      seq_sck,
  output logic      seq_din_en,
  output logic      seq_dout_en,
  output logic      seq_rst
);
  logic live;
  assign live = (state_d == HG_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_sck     <= 1'b0;
      seq_din_en  <= 1'b0;
      seq_dout_en <= 1'b0;
      seq_rst     <= 1'b0;
    end else begin
      seq_sck     <= live & s_sck;
      seq_din_en  <= live & ~s_cs_n;
      seq_dout_en <= live & ~s_cs_n;
      seq_rst     <= (state_d == HG_LOCK);
    end
  end
endmodule

// File: rtl/hold_gate.sv
module hold_gate
  import hold_gate_pkg::*;
#(
  parameter int   SYNC_STAGES = 2,
  parameter logic SCK_IDLE    = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_sck,
  input  logic pin_cs_n,
  input  logic pin_hold_n,
  output logic seq_sck,
  output logic seq_din_en,
  output logic seq_dout_en,
  output logic seq_rst
);
  localparam logic [PIN_W-1:0] PIN_RST = {1'b1, 1'b1, SCK_IDLE};

  logic [PIN_W-1:0] pins_raw, pins_s;
  logic             sync_sck, sync_cs_n, sync_hold_n;
  hg_state_e        st_q, st_d;

  assign pins_raw[PIN_SCK]  = pin_sck;
  assign pins_raw[PIN_CS]   = pin_cs_n;
  assign pins_raw[PIN_HOLD] = pin_hold_n;

  hold_pin_sync #(
    .W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)
  ) u_sync (
    .clk(clk), .rst(rst), .d(pins_raw), .q(pins_s)
  );

  assign sync_sck    = pins_s[PIN_SCK];
  assign sync_cs_n   = pins_s[PIN_CS];
  assign sync_hold_n = pins_s[PIN_HOLD];

  hold_state_ctl u_ctl (
    .clk(clk), .rst(rst),
    .s_sck(sync_sck), .s_cs_n(sync_cs_n), .s_hold_n(sync_hold_n),
    .state_q(st_q), .state_d(st_d)
  );

  hold_out_reg u_out (
    .clk(clk), .rst(rst), .state_d(st_d),
    .s_sck(sync_sck), .s_cs_n(sync_cs_n),
    .seq_sck(seq_sck), .seq_din_en(seq_din_en),
    .seq_dout_en(seq_dout_en), .seq_rst(seq_rst)
  );
endmodule

// File: rtl/hold_gate_chk.sv
module hold_gate_chk
  import hold_gate_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input logic      s_sck,
  input logic      s_cs_n,
  input logic      s_hold_n,
  input hg_state_e state_q,
  input logic      seq_sck,
  input logic      seq_din_en,
  input logic      seq_dout_en,
  input logic      seq_rst
);
  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (rst)
    s_cs_n |=> (!seq_din_en && !seq_dout_en)); // R7

  AST_ENTER_LOW: assert property (@(posedge clk) disable iff (rst)
    (state_q == HG_PAUSE && $past(state_q) == HG_RUN)
      |-> (!$past(s_sck) && !$past(s_hold_n) && !$past(s_cs_n))); // R4

  AST_EXIT_LOW: assert property (@(posedge clk) disable iff (rst)
    (state_q == HG_RUN && $past(state_q) == HG_PAUSE)
      |-> (!$past(s_sck) && $past(s_hold_n))); // R5

  AST_PAUSE_MASK: assert property (@(posedge clk) disable iff (rst)
    (state_q == HG_PAUSE) |-> (!seq_sck && !seq_din_en && !seq_dout_en && !seq_rst)); // R6

  AST_LOCK_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (state_q == HG_LOCK && $past(state_q) != HG_LOCK)
      |-> ($past(state_q) == HG_PAUSE && $past(s_cs_n))); // R8

  AST_LOCK_EXIT: assert property (@(posedge clk) disable iff (rst)
    (state_q != HG_LOCK && $past(state_q) == HG_LOCK)
      |-> ($past(s_cs_n) && $past(s_hold_n))); // R9

  AST_RST_QUIET: assert property (@(posedge clk) disable iff (rst)
    seq_rst |-> (!seq_sck && !seq_din_en && !seq_dout_en)); // R9
endmodule

bind hold_gate hold_gate_chk u_chk (
  .clk(clk), .rst(rst),
  .s_sck(sync_sck), .s_cs_n(sync_cs_n), .s_hold_n(sync_hold_n),
  .state_q(st_q),
  .seq_sck(seq_sck), .seq_din_en(seq_din_en),
  .seq_dout_en(seq_dout_en), .seq_rst(seq_rst)
);

// File: tb/sim_hold_gate.sv
`timescale 1ns/1ps
module sim_hold_gate;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0, cs_n = 1'b1, hold_n = 1'b1;
  logic q_sck, din_en, dout_en, srst;

  int checks = 0;
  int fails  = 0;
  int rises  = 0;
  logic prev_q = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hold_gate u0 (
    .clk(clk), .rst(rst), .pin_sck(sck), .pin_cs_n(cs_n), .pin_hold_n(hold_n),
    .seq_sck(q_sck), .seq_din_en(din_en), .seq_dout_en(dout_en), .seq_rst(srst)
  );

  always @(posedge clk) begin
    prev_q <= q_sck;
    if (q_sck && !prev_q) rises <= rises + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // outputs packed {sck,din,dout,rst}
  function automatic int outs();
    return {28'd0, q_sck, din_en, dout_en, srst};
  endfunction

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      sck = 1'b1; repeat (4) @(negedge clk);
      sck = 1'b0; repeat (4) @(negedge clk);
    end
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    chk("R1 outputs in reset", outs(), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 outputs after reset", outs(), 0);

    cs_n = 1'b0; settle();
    chk("R2 selected enables", outs(), 4'b0110);
    base = rises; pulses(3); settle();
    chk("R2 clock edges passed", rises - base, 3);

    hold_n = 1'b0; settle();
    chk("R3 pause with clock low", outs(), 0);
    base = rises; pulses(5); settle();
    chk("R6 no edges while paused", rises - base, 0);
    chk("R6 outputs while paused", outs(), 0);
    hold_n = 1'b1; settle();
    chk("R5 exit with clock low", outs(), 4'b0110);
    base = rises; pulses(2); settle();
    chk("R2 edges after pause", rises - base, 2);

    // sweep: both directions against both clock levels
    for (int dir = 0; dir < 2; dir++) begin
      for (int lvl = 0; lvl < 2; lvl++) begin
        // dir 0: entering pause from run; dir 1: leaving pause
        sck = 1'b0; hold_n = (dir == 0); settle();
        sck = lvl[0]; settle();
        hold_n = (dir != 0); settle();
        if (dir == 0)
          chk("R4 entry vs clock level", outs(), lvl ? 4'b1110 : 4'b0000);
        else
          chk("R5 exit vs clock level", outs(), lvl ? 4'b0000 : 4'b0110);
        sck = 1'b0; settle();
        chk(dir == 0 ? "R4 entry after clock low" : "R5 exit after clock low",
            outs(), dir == 0 ? 0 : 4'b0110);
      end
    end

    // deselect while running, pause pin ignored while deselected
    hold_n = 1'b1; sck = 1'b0; settle();
    cs_n = 1'b1; settle();
    chk("R7 deselected outputs", outs(), 0);
    hold_n = 1'b0; settle();
    chk("R7 pause pin ignored deselected", outs(), 0);
    hold_n = 1'b1; settle();
    cs_n = 1'b0; settle();
    chk("R7 no lock from deselected pause pin", outs(), 4'b0110);

    // lock: deselect during pause
    hold_n = 1'b0; settle();
    cs_n = 1'b1; settle();
    chk("R8 lock on deselect in pause", outs(), 4'b0001);
    cs_n = 1'b0; settle();
    chk("R9 reselect too early stays locked", outs(), 4'b0001);
    hold_n = 1'b1; settle();
    chk("R9 release while selected stays locked", outs(), 4'b0001);
    base = rises; pulses(2); settle();
    chk("R9 no edges while locked", rises - base, 0);
    cs_n = 1'b1; settle();
    chk("R9 lock clears with both high", outs(), 0);
    cs_n = 1'b0; settle();
    chk("R9 running after recovery", outs(), 4'b0110);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule